// File: doc/BRIEF.md
# Serial Register Transaction Master

This block is the controller end of a chained serial register port. Client logic hands it one command at a time: read or write, a device number, a broadcast flag, a 12-bit register address and, for writes, 16 bits of data. The block divides its system clock down to a serial clock. It marks the start of each transaction with a framing pattern on a command line that changes on both serial clock edges. It then moves four 16-bit packets over a single data pin that feeds the first device of the chain.

A write sends a request packet, an address packet, the data packet and a quiet interval packet. A read sends the request and address packets and then the interval packet. During the fourth packet the block stops driving the pin and shifts in the 16-bit value that the chain returns, MSB first. A one-cycle acknowledge marks the end of every transaction, and for a read the returned value appears on the read-data output at that moment.

Top module: `ser_reg_master`

## Requirements
- R1: While reset is asserted, and until the first accepted request, `srl_clk`, `srl_cmd`, `srl_oe`, `srl_dout`, `busy` and `req_ack` are 0 and `rd_data` is 0.
- R2: A request is accepted on a clock edge where `req_valid` is 1 and `busy` is 0. `busy` is 1 from the next cycle on, and `req_ack` is high for exactly one cycle, 64*DIV cycles after the accepting edge, with `busy` already 0 in that cycle.
- R3: Each serial bit lasts DIV system cycles. `srl_clk` is high for the first DIV/2 cycles and low for the rest, a transaction has exactly 64 serial clock periods, and `srl_clk` rests low when idle.
- R4: Taking one value of `srl_cmd` per serial clock half period, the transaction begins 1,1,1,1,0,0,0,0, and `srl_cmd` stays 0 for the rest of the transaction and while idle.
- R5: The first packet, MSB first, is opcode[3:0] (0001 for write, 0010 for read), the broadcast flag, device[5:0] and then five 0 bits.
- R6: In a write, the later packets are the address (four 0 bits above addr[11:0]), then the write data, then 16 zero bits of interval. All of them are sent MSB first, and each bit changes with the rising serial clock edge so that it is stable at the falling edge.
- R7: In a read, the address packet is followed by 16 zero bits of interval. Through the fourth packet (serial bits 48 to 63), `srl_oe` is 0 and `srl_dout` is 0. `srl_oe` is 1 at every other bit of any transaction.
- R8: In a read, `srl_din` is sampled at the falling serial clock edge of bits 48 to 63, the first sample being data bit 15. The 16 samples appear on `rd_data` in the cycle in which `req_ack` is high.
- R9: `rd_data` changes only in a read's acknowledge cycle or by reset. A write leaves it unchanged.
- R10: `req_valid` is ignored while `busy` is 1. The transaction in progress keeps its bits and gives exactly one acknowledge, and no new transaction starts unless `req_valid` is asserted while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Command request |
| req_read | input | 1 | 1 = read, 0 = write |
| req_bcast | input | 1 | Broadcast to all devices |
| req_dev | input | 6 | Device number |
| req_addr | input | 12 | Register address |
| req_wdata | input | 16 | Write data |
| req_ack | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Transaction in progress |
| rd_data | output | 16 | Value returned by the last read |
| srl_clk | output | 1 | Serial clock to all devices |
| srl_cmd | output | 1 | Framing line to all devices |
| srl_dout | output | 1 | Serial data toward the chain |
| srl_oe | output | 1 | Output enable for the data pin |
| srl_din | input | 1 | Serial data returned by the chain |

## Verification
The serial clock, command line and data pin all come from flops loaded on the same system edge. The bench therefore samples every pin at the falling system clock edge, and it records each serial bit at the negative edge where it first sees `srl_clk` low, and each command half period at the edge where `srl_clk` changes. Counting from the accepting edge, the acknowledge is due at the 64*DIV-th system edge, so the bench expects `req_ack` in the negedge sample with that index. It checks `rd_data` in the same sample. The bench drives the returned read bit in the negedge after each serial clock rise, one half period before the block samples it at the fall.

// File: rtl/srm_pkg.sv
package srm_pkg;
  localparam int PKT_W   = 16;
  localparam int N_PKT   = 4;
  localparam int XFER_W  = PKT_W * N_PKT;
  localparam int DEV_W   = 6;
  localparam int ADDR_W  = 12;
  localparam int DATA_W  = 16;
  localparam int FRAME_W = 8;

  typedef enum logic [3:0] {
    OPC_WRITE = 4'b0001,
    OPC_READ  = 4'b0010
  } srm_opc_e;

  // Request packet: opcode, broadcast, device, zero fill (MSB first on the wire)
  function automatic logic [PKT_W-1:0] pack_req(input logic rd, input logic bc,
                                                input logic [DEV_W-1:0] dev);
    srm_opc_e opc;
    opc = rd ? OPC_READ : OPC_WRITE;
    return {opc, bc, dev, {(PKT_W-4-1-DEV_W){1'b0}}};
  endfunction
endpackage

// File: rtl/srm_timebase.sv
module srm_timebase #(
  parameter int DIV       = 4,
  parameter int NBITS     = 64,
  parameter logic [7:0] FRAME_PAT = 8'b1111_0000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  output logic                     active,
  output logic [$clog2(NBITS)-1:0] bit_idx,
  output logic                     shift_en,
  output logic                     sample_en,
  output logic                     done,
  output logic                     sck,
  output logic                     cmd
);
  localparam int HALF = DIV / 2;
  localparam int PW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int BW   = $clog2(NBITS);

  logic          act_q, act_n;
  logic [PW-1:0] ph_q, ph_n;
  logic [BW-1:0] bit_q, bit_n;
  logic          sck_q, sck_n, cmd_q, cmd_n;
  logic [BW:0]   half_n;

  // next-state
  always_comb begin
    act_n = act_q;
    ph_n  = ph_q;
    bit_n = bit_q;
    done  = 1'b0;
    if (!act_q) begin
      if (start) begin
        act_n = 1'b1;
        ph_n  = '0;
        bit_n = '0;
      end
    end else if (ph_q == PW'(DIV - 1)) begin
      ph_n = '0;
      if (bit_q == BW'(NBITS - 1)) begin
        act_n = 1'b0;
        done  = 1'b1;
      end else begin
        bit_n = bit_q + 1'b1;
      end
    end else begin
      ph_n = ph_q + 1'b1;
    end
  end

  // pin values decoded from the next state, so the pins are flops
  always_comb begin
    half_n = {bit_n, (ph_n >= PW'(HALF))};
    sck_n  = act_n && (ph_n < PW'(HALF));
    cmd_n  = act_n && (half_n < (BW+1)'(8)) && FRAME_PAT[3'd7 - half_n[2:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      ph_q  <= '0;
      bit_q <= '0;
      sck_q <= 1'b0;
      cmd_q <= 1'b0;
    end else begin
      act_q <= act_n;
      ph_q  <= ph_n;
      bit_q <= bit_n;
      sck_q <= sck_n;
      cmd_q <= cmd_n;
    end
  end

  assign active    = act_q;
  assign bit_idx   = bit_q;
  assign shift_en  = act_q && (ph_q == PW'(DIV - 1));
  assign sample_en = act_q && (ph_q == PW'(HALF - 1));
  assign sck       = sck_q;
  assign cmd       = cmd_q;

  a_r3_idle_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
    !act_q |-> !sck_q);
  a_r3_clk_low_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !sck_q);
  a_r4_cmd_outside_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_q || bit_q >= BW'(2)) |-> !cmd_q);
  a_r3_clk_high_at_bit_start: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && ph_q == '0) |-> sck_q);
endmodule

// File: rtl/srm_shifter.sv
module srm_shifter #(
  parameter int NBITS = 64,
  parameter int CAP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NBITS-1:0] load_word,
  input  logic             shift_en,
  input  logic             cap_en,
  input  logic             sin,
  output logic             sout,
  output logic [CAP_W-1:0] cap_word
);
  logic [NBITS-1:0] sh_q, sh_n;
  logic [CAP_W-1:0] cap_q, cap_n;

  always_comb begin
    sh_n  = sh_q;
    cap_n = cap_q;
    if (load)          sh_n = load_word;
    else if (shift_en) sh_n = {sh_q[NBITS-2:0], 1'b0};
    if (cap_en)        cap_n = {cap_q[CAP_W-2:0], sin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cap_q <= '0;
    end else begin
      sh_q  <= sh_n;
      cap_q <= cap_n;
    end
  end

  assign sout     = sh_q[NBITS-1];
  assign cap_word = cap_q;
endmodule

// File: rtl/ser_reg_master.sv
module ser_reg_master
  import srm_pkg::*;
#(
  parameter int DIV = 4,
  parameter logic [7:0] FRAME_PAT = 8'b1111_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_read,
  input  logic              req_bcast,
  input  logic [DEV_W-1:0]  req_dev,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ack,
  output logic              busy,
  output logic [DATA_W-1:0] rd_data,
  output logic              srl_clk,
  output logic              srl_cmd,
  output logic              srl_dout,
  output logic              srl_oe,
  input  logic              srl_din
);
  localparam int BW      = $clog2(XFER_W);
  localparam int RD_FROM = (N_PKT - 1) * PKT_W;

  logic              start, active, shift_en, sample_en, done, sout, in_rd_pkt;
  logic [BW-1:0]     bit_idx;
  logic [XFER_W-1:0] load_word;
  logic [DATA_W-1:0] cap_word;
  logic              is_rd_q, is_rd_n, ack_q;
  logic [DATA_W-1:0] rd_q, rd_n;

  assign start = req_valid && !active;

  always_comb begin
    load_word = {pack_req(req_read, req_bcast, req_dev),
                 PKT_W'(req_addr),
                 req_read ? {PKT_W{1'b0}} : PKT_W'(req_wdata),
                 {PKT_W{1'b0}}};
  end

  srm_timebase #(.DIV(DIV), .NBITS(XFER_W), .FRAME_PAT(FRAME_PAT)) u_tb (
    .clk(clk), .rst_n(rst_n), .start(start), .active(active), .bit_idx(bit_idx),
    .shift_en(shift_en), .sample_en(sample_en), .done(done),
    .sck(srl_clk), .cmd(srl_cmd));

  assign in_rd_pkt = is_rd_q && (bit_idx >= BW'(RD_FROM));

  srm_shifter #(.NBITS(XFER_W), .CAP_W(DATA_W)) u_sh (
    .clk(clk), .rst_n(rst_n), .load(start), .load_word(load_word),
    .shift_en(shift_en), .cap_en(sample_en && in_rd_pkt), .sin(srl_din),
    .sout(sout), .cap_word(cap_word));

  always_comb begin
    is_rd_n = start ? req_read : is_rd_q;
    rd_n    = (done && is_rd_q) ? cap_word : rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      is_rd_q <= 1'b0;
      rd_q    <= '0;
      ack_q   <= 1'b0;
    end else begin
      is_rd_q <= is_rd_n;
      rd_q    <= rd_n;
      ack_q   <= done;
    end
  end

  assign srl_oe   = active && !in_rd_pkt;
  assign srl_dout = srl_oe && sout;
  assign busy     = active;
  assign req_ack  = ack_q;
  assign rd_data  = rd_q;

  a_r2_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> !req_ack);
  a_r2_ack_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> !busy);
  a_r2_start_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));
  a_r9_rd_data_changes_at_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data) |-> req_ack);
  a_r7_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!srl_oe && !srl_dout));
  a_r7_no_drive_when_released: assert property (@(posedge clk) disable iff (!rst_n)
    !srl_oe |-> !srl_dout);
endmodule

// File: tb/ser_reg_master_tb_top.sv
module ser_reg_master_tb_top;
  localparam int DIV  = 4;
  localparam int HALF = DIV / 2;
  localparam int TXN  = 64 * DIV;

  // {read, bcast, dev[5:0], addr[11:0], wdata[15:0], returned[15:0]}
  localparam logic [51:0] VEC [0:5] = '{
    {1'b0, 1'b0, 6'h05, 12'h0A3, 16'hBEEF, 16'h0000},
    {1'b1, 1'b0, 6'h1F, 12'hFFF, 16'h1234, 16'hA5C3},
    {1'b0, 1'b1, 6'h00, 12'h800, 16'h8001, 16'h0000},
    {1'b1, 1'b1, 6'h2A, 12'h001, 16'h0000, 16'hFFFF},
    {1'b1, 1'b0, 6'h3F, 12'h555, 16'h0000, 16'h0001},
    {1'b0, 1'b0, 6'h12, 12'h7E1, 16'h0000, 16'h0000}
  };

  logic clk, rst_n, req_valid, req_read, req_bcast;
  logic [5:0] req_dev;
  logic [11:0] req_addr;
  logic [15:0] req_wdata, rd_data;
  logic req_ack, busy, srl_clk, srl_cmd, srl_dout, srl_oe, srl_din;

  int tests = 0, fails = 0, wd_cnt = 0;
  logic [15:0] exp_rd;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  ser_reg_master #(.DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
    .req_bcast(req_bcast), .req_dev(req_dev), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ack(req_ack), .busy(busy), .rd_data(rd_data),
    .srl_clk(srl_clk), .srl_cmd(srl_cmd), .srl_dout(srl_dout), .srl_oe(srl_oe),
    .srl_din(srl_din));

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    wd_cnt++;
    if (wd_cnt > 150000) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic run_txn(input logic [51:0] v, input bit poke);
    logic rd, bc;
    logic [5:0] dev;
    logic [11:0] addr;
    logic [15:0] wd, rv;
    logic [63:0] exp_s, got_s, got_oe, exp_oe;
    logic [127:0] halves;
    int hn, rises, falls, hi, ackc, ack_at;
    bit ack_busy_bad;
    logic prev;
    {rd, bc, dev, addr, wd, rv} = v;
    exp_s  = {(rd ? 4'b0010 : 4'b0001), bc, dev, 5'b0, 4'b0, addr,
              (rd ? 16'h0 : wd), 16'h0};
    exp_oe = rd ? {48'hFFFF_FFFF_FFFF, 16'h0} : {64{1'b1}};
    hn = 0; rises = 0; falls = 0; hi = 0; ackc = 0; ack_at = -1;
    ack_busy_bad = 0; halves = '0; got_s = '0; got_oe = '0; prev = 1'b0;
    @(negedge clk);
    req_read = rd; req_bcast = bc; req_dev = dev; req_addr = addr; req_wdata = wd;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy === 1'b1 && srl_clk === 1'b1, "R2", "busy/clk after accept",
        {busy, srl_clk}, 2'b11);
    for (int cyc = 0; cyc < TXN + 4; cyc++) begin
      if (cyc > 0) @(negedge clk);
      if (poke && cyc == 100) begin
        req_valid = 1'b1; req_read = ~rd; req_dev = ~dev;
        req_addr = ~addr; req_wdata = ~wd;
      end
      if (poke && cyc == 102) req_valid = 1'b0;
      if (srl_clk !== prev) begin
        if (hn < 128) halves[hn] = srl_cmd;
        hn++;
      end
      if (srl_clk && !prev) begin
        srl_din = (rd && rises >= 48) ? rv[15 - (rises - 48)] : 1'b0;
        rises++;
      end
      if (!srl_clk && prev) begin
        if (falls < 64) begin
          got_s[63 - falls]  = srl_dout;
          got_oe[63 - falls] = srl_oe;
        end
        falls++;
      end
      if (srl_clk) hi++;
      if (req_ack) begin
        ackc++;
        ack_at = cyc;
        if (busy) ack_busy_bad = 1;
      end
      prev = srl_clk;
    end
    srl_din = 1'b0;
    chk(hn == 128 && halves == 128'hF, "R4", "cmd half periods", halves, 128'hF);
    chk(rises == 64 && hi == 64 * HALF, "R3", "clk periods/high cycles",
        {rises[15:0], hi[15:0]}, {16'd64, 16'(64 * HALF)});
    chk(got_s[63:48] == exp_s[63:48], "R5", "request packet", got_s[63:48], exp_s[63:48]);
    chk(got_s[47:0] == exp_s[47:0], rd ? "R7" : "R6", "later packets",
        got_s[47:0], exp_s[47:0]);
    chk(got_oe == exp_oe, "R7", "pin enable per bit", got_oe, exp_oe);
    chk(ackc == 1 && ack_at == TXN && !ack_busy_bad, "R2", "ack timing",
        {ackc[15:0], ack_at[15:0]}, {16'd1, 16'(TXN)});
    if (rd) exp_rd = rv;
    chk(rd_data === exp_rd, rd ? "R8" : "R9", "rd_data", rd_data, exp_rd);
    if (poke) chk(busy === 1'b0, "R10", "no restart after ignored request", busy, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_read = 1'b0; req_bcast = 1'b0;
    req_dev = '0; req_addr = '0; req_wdata = '0; srl_din = 1'b0; exp_rd = '0;
    repeat (3) @(negedge clk);
    chk({srl_clk, srl_cmd, srl_oe, srl_dout, busy, req_ack} === 6'b0 && rd_data === 16'h0,
        "R1", "reset state", {srl_clk, srl_cmd, srl_oe, srl_dout, busy, req_ack, rd_data},
        22'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(busy === 1'b0 && srl_clk === 1'b0, "R1", "idle after reset", {busy, srl_clk}, 2'b00);

    // vector table
    for (int i = 0; i < 6; i++) run_txn(VEC[i], 1'b0);

    // request while busy: ignored (R10)
    run_txn({1'b1, 1'b0, 6'h15, 12'h3C3, 16'h0000, 16'h6E91}, 1'b1);
    run_txn({1'b0, 1'b1, 6'h2B, 12'hA0F, 16'h7FFE, 16'h0000}, 1'b1);

    // reset in the middle of a transaction (R1)
    @(negedge clk);
    req_read = 1'b0; req_dev = 6'h01; req_addr = 12'h111; req_wdata = 16'hFFFF;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (60) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk({srl_clk, srl_cmd, srl_oe, srl_dout, busy, req_ack} === 6'b0 && rd_data === 16'h0,
        "R1", "reset mid transaction",
        {srl_clk, srl_cmd, srl_oe, srl_dout, busy, req_ack, rd_data}, 22'h0);
    exp_rd = 16'h0;
    @(negedge clk);
    rst_n = 1'b1;
    run_txn({1'b1, 1'b0, 6'h07, 12'h0F0, 16'h0000, 16'h8000}, 1'b0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule